// File: doc/BRIEF.md
# Real-Time Clock Prescaler and BCD Calendar

This block is the timekeeping core of a real-time clock. It runs from a 32.768 kHz source clock. A two-stage divider turns that clock into a one-second tick. The first stage is a free-running asynchronous divider. The second stage is a synchronous down-counter whose live value is the sub-second count. Each second tick advances a binary-coded-decimal time of day (seconds, minutes, hours, with an optional 12-hour mode and a PM flag). At the end of the day it advances a BCD date (day, month, two-digit year, weekday).

Software reaches the block through a plain synchronous register bus. There is no data stream, so there is no back-pressure: a write takes effect on the clock edge where `bus_wr` is high, and the read data follows `bus_addr` combinationally.

Writes are guarded in two layers:
- The key register must first receive 0xCA and then 0x53, in that order.
- Time, date, control and prescaler writes also need the halted initialization mode. Software requests it through the status register and waits for the acknowledge flag.

Leaving init mode restarts counting four source cycles later. At that point a resynchronised flag rises.

Top module: `rtc_core`

## Requirements
- R1: After reset, reads return:
  - time 0x000000
  - date 0x00C101 (year 00, weekday 6, month 01, day 01)
  - control 0
  - status 0
  - prescaler 0x7F00FF (async 127, sync 255)
  - sub-second 0x0000FF
- R2: Writes to register 5 (the key) move a lock state. A value of 0xCA arms it. 0x53 right after 0xCA unlocks. Any other value locks. While locked, every write to another register is ignored.
- R3: When unlocked, writing status bit 7 = 1 requests init mode. Status bit 7 reads back the request. Status bit 6 (acknowledge) rises one cycle after the request. Writing bit 7 = 0 clears both bits on the same edge.
- R4: Writes to time (0), date (1), control (2) and prescaler (4) are ignored unless status bit 6 is set, even when unlocked.
- R5: On init exit, status bit 5 clears. Counting restarts, and bit 5 sets, four cycles after the exit write.
- R6: Prescaler layout is sync divide S in bits 14:0 and async divide A in bits 22:16. The sub-second register (6) reloads to S and counts down by one every A+1 cycles. It reloads to S after 0. Seconds advance on that reload, once every (A+1)(S+1) cycles.
- R7: Time register layout, all BCD:
  - PM flag: bit 22
  - hours: 21:16
  - minutes: 14:8
  - seconds: 6:0

  With control bit 6 = 0 (24-hour mode), time counts 00:00:00 to 23:59:59, wraps to 00:00:00, and advances the date.
- R8: With control bit 6 = 1 (12-hour mode), hours run 12, 1, ... 11. PM toggles on the 11:59:59 to 12:00:00 step. The date advances when PM 11:59:59 steps to AM 12:00:00.
- R9: Date layout, BCD: year 23:16, weekday 15:13, month 12:8, day 5:0. The day rolls to 01 after the last day of the month. Months have 31 or 30 days, and February has 29 when the year is divisible by 4, else 28.
- R10: At a day change the weekday steps 1..7 and wraps 7 to 1. Month 12 rolls to 01 and increments the year. Year 99 wraps to 00.
- R11: While status bit 6 is set, the time and date do not change except by writes, no second pulse occurs, and the sub-second register reads S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for the selected register |
| second_pulse | output | 1 | One-cycle pulse on every calendar second |

## Verification
The hardest conditions to reach from the ports are the rare calendar rollovers: last day of each month in leap and non-leap years, the December/year-99 wrap, and the 12-hour noon and midnight edges. At the default 1 Hz rate these would take days of source cycles. The bench reprograms both dividers to zero inside init mode so that a second elapses every cycle. It then plants times and dates just before each rollover and sweeps a full day plus the 12-hour crossings, checking the time every cycle. A short run with small nonzero dividers checks the sub-second countdown and second spacing arithmetically.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    REG_TIME   = 3'd0,
    REG_DATE   = 3'd1,
    REG_CTRL   = 3'd2,
    REG_STAT   = 3'd3,
    REG_PRE    = 3'd4,
    REG_KEY    = 3'd5,
    REG_SUBSEC = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    LK_SHUT,
    LK_ARMED,
    LK_OPEN
  } lock_e;

  localparam logic [7:0] KEY_ARM  = 8'hCA;
  localparam logic [7:0] KEY_OPEN = 8'h53;

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    tens = v / 7'd10;
    return {tens[3:0], 4'(v - tens * 7'd10)};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prediv.sv
module rtc_prediv #(
  parameter int ASYNC_W   = 7,
  parameter int SYNC_W    = 15,
  parameter int ASYNC_RST = 127,
  parameter int SYNC_RST  = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              load,
  input  logic [ASYNC_W-1:0] async_in,
  input  logic [SYNC_W-1:0]  sync_in,
  output logic [23:0]        prer,
  output logic [SYNC_W-1:0]  subsec,
  output logic               sec_tick
);

  logic [ASYNC_W-1:0] a_div, a_cnt;
  logic [SYNC_W-1:0]  s_div;
  logic               ck_a;

  assign ck_a     = !hold && (a_cnt == '0);
  assign sec_tick = ck_a && (subsec == '0);

  always_comb begin
    prer = '0;
    prer[16 +: ASYNC_W]  = a_div;
    prer[SYNC_W-1:0]     = s_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_div  <= ASYNC_W'(ASYNC_RST);
      s_div  <= SYNC_W'(SYNC_RST);
      a_cnt  <= ASYNC_W'(ASYNC_RST);
      subsec <= SYNC_W'(SYNC_RST);
    end else begin
      if (load) begin
        a_div <= async_in;
        s_div <= sync_in;
      end
      if (hold) begin
        a_cnt  <= a_div;
        subsec <= s_div;
      end else begin
        a_cnt <= ck_a ? a_div : a_cnt - 1'b1;
        if (ck_a) subsec <= (subsec == '0) ? s_div : subsec - 1'b1;
      end
    end
  end

  AST_SUBSEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> subsec <= s_div) else $error("subsec above divide"); // R6
  AST_ASYNC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> a_cnt <= a_div) else $error("async count above divide"); // R6

endmodule

// File: rtl/rtc_tod.sv
module rtc_tod
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        fmt12,
  input  logic        load,
  input  logic [22:0] load_val,
  output logic [22:0] time_q,
  output logic        day_tick
);

  logic [6:0]  sec_b, min_b, hr_b, hr_n;
  logic        sec_wrap, min_wrap, pm_n, day_end;
  logic [22:0] tod_nx;

  assign sec_b    = bcd_to_bin({1'b0, time_q[6:0]});
  assign min_b    = bcd_to_bin({1'b0, time_q[14:8]});
  assign hr_b     = bcd_to_bin({2'b0, time_q[21:16]});
  assign sec_wrap = (sec_b == 7'd59);
  assign min_wrap = (min_b == 7'd59);

  always_comb begin
    hr_n    = hr_b + 7'd1;
    pm_n    = time_q[22];
    day_end = 1'b0;
    if (fmt12) begin
      if (hr_b == 7'd12) begin
        hr_n = 7'd1;
      end else if (hr_b == 7'd11) begin
        hr_n    = 7'd12;
        pm_n    = !time_q[22];
        day_end = time_q[22];
      end
    end else if (hr_b == 7'd23) begin
      hr_n    = 7'd0;
      day_end = 1'b1;
    end
  end

  always_comb begin
    tod_nx = time_q;
    tod_nx[6:0] = sec_wrap ? 7'd0 : 7'(bin_to_bcd(sec_b + 7'd1));
    if (sec_wrap) tod_nx[14:8] = min_wrap ? 7'd0 : 7'(bin_to_bcd(min_b + 7'd1));
    if (sec_wrap && min_wrap) begin
      tod_nx[21:16] = 6'(bin_to_bcd(hr_n));
      tod_nx[22]    = pm_n;
    end
  end

  assign day_tick = sec_tick && sec_wrap && min_wrap && day_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        time_q <= '0;
    else if (load)     time_q <= load_val & 23'h7F7F7F;
    else if (sec_tick) time_q <= tod_nx;
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && sec_wrap && !load |=> time_q[6:0] == 7'd0) else $error("seconds did not wrap"); // R7
  AST_DAY_HOUR: assert property (@(posedge clk) disable iff (!rst_n)
    day_tick && !load |=> time_q[21:16] == ($past(fmt12) ? 6'h12 : 6'h00)) else $error("bad hour at day change"); // R8

endmodule

// File: rtl/rtc_cal.sv
module rtc_cal
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        day_tick,
  input  logic        load,
  input  logic [23:0] load_val,
  output logic [23:0] date_q
);

  localparam logic [23:0] DATE_RST  = 24'h00C101;
  localparam logic [23:0] DATE_MASK = 24'hFFFF3F;

  logic [6:0]  yr_b, mon_b, day_b;
  logic        last_day;
  logic [23:0] date_nx;

  assign yr_b     = bcd_to_bin(date_q[23:16]);
  assign mon_b    = bcd_to_bin({3'b0, date_q[12:8]});
  assign day_b    = bcd_to_bin({2'b0, date_q[5:0]});
  assign last_day = (day_b == month_len(mon_b, yr_b));

  always_comb begin
    date_nx = date_q;
    date_nx[15:13] = (date_q[15:13] == 3'd7) ? 3'd1 : date_q[15:13] + 3'd1;
    if (!last_day) begin
      date_nx[5:0] = 6'(bin_to_bcd(day_b + 7'd1));
    end else begin
      date_nx[5:0] = 6'h01;
      if (mon_b == 7'd12) begin
        date_nx[12:8]  = 5'h01;
        date_nx[23:16] = (yr_b == 7'd99) ? 8'h00 : bin_to_bcd(yr_b + 7'd1);
      end else begin
        date_nx[12:8]  = 5'(bin_to_bcd(mon_b + 7'd1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        date_q <= DATE_RST;
    else if (load)     date_q <= load_val & DATE_MASK;
    else if (day_tick) date_q <= date_nx;
  end

  AST_WDAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    day_tick && !load |=> date_q[15:13] != 3'd0) else $error("weekday zero"); // R10
  AST_DAY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    day_tick && last_day && !load |=> date_q[5:0] == 6'h01) else $error("day not restarted"); // R9

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ASYNC_W    = 7,
  parameter int SYNC_W     = 15,
  parameter int ASYNC_RST  = 127,
  parameter int SYNC_RST   = 255,
  parameter int RESUME_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [23:0] bus_wdata,
  output logic [23:0] bus_rdata,
  output logic        second_pulse
);

  localparam int RW = $clog2(RESUME_CYC + 1);

  lock_e              lock_q;
  logic               init_req, initf, rsf, fmt12;
  logic [RW-1:0]      resume_cnt;
  logic               wr_key, wr_open, cal_wr, stat_wr, run;
  logic [22:0]        time_q;
  logic [23:0]        date_q, prer;
  logic [SYNC_W-1:0]  subsec;
  logic               sec_tick, day_tick;

  assign wr_key  = bus_wr && (bus_addr == REG_KEY);
  assign wr_open = bus_wr && (lock_q == LK_OPEN);
  assign cal_wr  = wr_open && initf;
  assign stat_wr = wr_open && (bus_addr == REG_STAT);
  assign run     = !init_req && (resume_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= LK_SHUT;
    end else if (wr_key) begin
      if (bus_wdata[7:0] == KEY_ARM)                              lock_q <= LK_ARMED;
      else if (lock_q == LK_ARMED && bus_wdata[7:0] == KEY_OPEN)  lock_q <= LK_OPEN;
      else                                                        lock_q <= LK_SHUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req   <= 1'b0;
      initf      <= 1'b0;
      rsf        <= 1'b0;
      resume_cnt <= RW'(RESUME_CYC);
    end else if (stat_wr && !bus_wdata[7] && init_req) begin
      init_req   <= 1'b0;
      initf      <= 1'b0;
      rsf        <= 1'b0;
      resume_cnt <= RW'(RESUME_CYC);
    end else begin
      initf <= init_req;
      if (stat_wr && bus_wdata[7]) begin
        init_req   <= 1'b1;
        resume_cnt <= '0;
      end else if (resume_cnt != '0) begin
        resume_cnt <= resume_cnt - 1'b1;
        if (resume_cnt == RW'(1)) rsf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  fmt12 <= 1'b0;
    else if (cal_wr && bus_addr == REG_CTRL)     fmt12 <= bus_wdata[6];
  end

  rtc_prediv #(
    .ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W), .ASYNC_RST(ASYNC_RST), .SYNC_RST(SYNC_RST)
  ) u_prediv (
    .clk(clk), .rst_n(rst_n), .hold(!run),
    .load(cal_wr && bus_addr == REG_PRE),
    .async_in(bus_wdata[16 +: ASYNC_W]), .sync_in(bus_wdata[SYNC_W-1:0]),
    .prer(prer), .subsec(subsec), .sec_tick(sec_tick)
  );

  rtc_tod u_tod (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .fmt12(fmt12),
    .load(cal_wr && bus_addr == REG_TIME), .load_val(bus_wdata[22:0]),
    .time_q(time_q), .day_tick(day_tick)
  );

  rtc_cal u_cal (
    .clk(clk), .rst_n(rst_n), .day_tick(day_tick),
    .load(cal_wr && bus_addr == REG_DATE), .load_val(bus_wdata),
    .date_q(date_q)
  );

  assign second_pulse = sec_tick;

  always_comb begin
    case (bus_addr)
      REG_TIME:   bus_rdata = {1'b0, time_q};
      REG_DATE:   bus_rdata = date_q;
      REG_CTRL:   bus_rdata = {17'b0, fmt12, 6'b0};
      REG_STAT:   bus_rdata = {16'b0, init_req, initf, rsf, 5'b0};
      REG_PRE:    bus_rdata = prer;
      REG_SUBSEC: bus_rdata = 24'(subsec);
      default:    bus_rdata = '0;
    endcase
  end

  AST_LOCKED_NO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q != LK_OPEN && !init_req |=> !init_req) else $error("init while locked"); // R2
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(initf) |-> init_req && $past(init_req)) else $error("ack without request"); // R3
  AST_RSF_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_req) |-> !rsf) else $error("resync flag kept on exit"); // R5
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    initf |-> !sec_tick) else $error("tick during init"); // R11
  AST_FROZEN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    initf && !(cal_wr && bus_addr == REG_TIME) |=> $stable(time_q)) else $error("time moved in init"); // R11

endmodule

// File: tb/rtc_core_test.sv
`timescale 1ns/1ps
module rtc_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic        second_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_core uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .second_pulse(second_pulse)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, output logic [23:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [23:0] tod24(input int n);
    logic [23:0] r = '0;
    r[21:16] = 6'(bcd(n / 3600));
    r[14:8]  = 7'(bcd((n / 60) % 60));
    r[6:0]   = 7'(bcd(n % 60));
    return r;
  endfunction

  function automatic logic [23:0] tod12(input int n);
    logic [23:0] r;
    int h;
    h = (n / 3600) % 12;
    if (h == 0) h = 12;
    r = tod24(n % 3600);
    r[21:16] = 6'(bcd(h));
    r[22]    = (n / 3600) >= 12;
    return r;
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [23:0] mkdate(input int y, input int wd, input int m, input int d);
    return {bcd(y), 3'(wd), 5'(bcd(m)), 2'b00, 6'(bcd(d))};
  endfunction

  task automatic enter_init();
    logic [23:0] s;
    bw(3'd5, 24'hCA);
    bw(3'd5, 24'h53);
    bw(3'd3, 24'h80);
    for (int i = 0; i < 8; i++) begin
      br(3'd3, s);
      if (s[6]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    logic [23:0] v, v2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    br(3'd0, v); chk("R1 time", v, 24'h000000);
    br(3'd1, v); chk("R1 date", v, 24'h00C101);
    br(3'd2, v); chk("R1 ctrl", v, 24'h000000);
    br(3'd3, v); chk("R1 status", v, 24'h000000);
    br(3'd4, v); chk("R1 prescaler", v, 24'h7F00FF);
    br(3'd6, v); chk("R1 subsec", v, 24'h0000FF);

    // R2 locked writes ignored, wrong key order relocks
    bw(3'd3, 24'h80);
    br(3'd3, v); chk("R2 locked init", v & 24'h80, 24'h0);
    bw(3'd5, 24'hCA); bw(3'd5, 24'h12); bw(3'd5, 24'h53);
    bw(3'd3, 24'h80);
    br(3'd3, v); chk("R2 bad key", v & 24'h80, 24'h0);

    // R4 unlocked but outside init
    bw(3'd5, 24'hCA); bw(3'd5, 24'h53);
    bw(3'd0, 24'h123456);
    br(3'd0, v); chk("R4 time", v, 24'h000000);
    bw(3'd4, 24'h000000);
    br(3'd4, v); chk("R4 prescaler", v, 24'h7F00FF);
    bw(3'd2, 24'h000040);
    br(3'd2, v); chk("R4 ctrl", v, 24'h000000);

    // R3 handshake
    bw(3'd3, 24'h80);
    br(3'd3, v); chk("R3 request", v & 24'hC0, 24'h80);
    @(negedge clk);
    br(3'd3, v); chk("R3 ack", v & 24'hC0, 24'hC0);

    // R2 relock, then clearing init is ignored
    bw(3'd5, 24'hFF);
    bw(3'd3, 24'h00);
    br(3'd3, v); chk("R2 relock", v & 24'hC0, 24'hC0);
    bw(3'd5, 24'hCA); bw(3'd5, 24'h53);

    // R6 prescaler A=1 S=3
    bw(3'd4, 24'h010003);
    bw(3'd0, 24'h000000);
    br(3'd6, v); chk("R11 subsec reads S", v, 24'h000003);
    bw(3'd3, 24'h00);
    br(3'd3, v); chk("R5 exit clears", v, 24'h000000);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      br(3'd3, v); chk("R5 waiting", v, 24'h000000);
    end
    @(negedge clk);
    br(3'd3, v); chk("R5 resumed", v, 24'h000020);
    for (int k = 0; k < 48; k++) begin
      br(3'd6, v); chk("R6 subsec", v, 24'(3 - ((k / 2) % 4)));
      br(3'd0, v); chk("R6 seconds", v, tod24(k / 8));
      @(negedge clk);
    end

    // R11 frozen in init with fastest dividers
    enter_init();
    bw(3'd4, 24'h000000);
    bw(3'd0, 24'h000000);
    bw(3'd1, 24'h00C101);
    repeat (10) @(negedge clk);
    br(3'd0, v);  chk("R11 time frozen", v, 24'h000000);
    br(3'd1, v2); chk("R11 date frozen", v2, 24'h00C101);

    // R7 full-day sweep, 24-hour mode
    bw(3'd3, 24'h00);
    repeat (4) @(negedge clk);
    for (int n = 0; n <= 86400; n++) begin
      br(3'd0, v);
      chk("R7 time", v, tod24(n % 86400));
      @(negedge clk);
    end
    enter_init();
    br(3'd1, v); chk("R10 day after sweep", v, mkdate(0, 7, 1, 2));

    // R8 12-hour mode across midnight and noon
    bw(3'd2, 24'h000040);
    for (int p = 0; p < 2; p++) begin
      int start, len;
      start = (p == 0) ? 22 * 3600 : 10 * 3600 + 3000;
      len   = (p == 0) ? 14400 : 10000;
      if (p == 1) enter_init();
      bw(3'd0, tod12(start));
      bw(3'd3, 24'h00);
      repeat (4) @(negedge clk);
      for (int n = 0; n <= len; n++) begin
        br(3'd0, v);
        chk("R8 time", v, tod12((start + n) % 86400));
        @(negedge clk);
      end
    end
    enter_init();
    br(3'd1, v); chk("R8 date advanced", v, mkdate(0, 1, 1, 3));

    // R9 R10 month ends
    bw(3'd2, 24'h000000);
    for (int yi = 0; yi < 7; yi++) begin
      int ys[7] = '{0, 1, 2, 3, 4, 98, 99};
      for (int m = 1; m <= 12; m++) begin
        int y, wd, ny, nm;
        y  = ys[yi];
        wd = (m % 7) + 1;
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? (y + 1) % 100 : y;
        enter_init();
        bw(3'd0, tod24(86399));
        bw(3'd1, mkdate(y, wd, m, mlen(m, y)));
        bw(3'd3, 24'h00);
        repeat (6) @(negedge clk);
        br(3'd1, v);
        chk("R9 R10 rollover", v, mkdate(ny, (wd % 7) + 1, nm, 1));
      end
    end

    finish_run();
  end

endmodule